// File: doc/BRIEF.md
# Double-Buffered DAC Update Controller

This block sits between a serial bus receiver and a digital-to-analog converter core. It takes complete 24-bit command words and applies them to two registers. The first is a staging (input) register. The second is the DAC register, which drives the converter code. The block also tracks a power-down state.

An active-low load pin, asynchronous to the clock, can copy the staging register into the DAC register without a bus command. The pin is synchronized inside the block, and its effect depends on whether a bus transfer is in progress. When the converter wakes from power-down, a settling timer runs and a busy flag stays high until the output is assumed stable.

Parameters choose:
- the converter resolution (16, 14 or 12 bits);
- whether reset loads zero scale or midscale;
- the length of the settling window in clock cycles.

Top module: `dac_update_ctrl`

## Requirements
- R1: Opcode 4'h0 (word bits 23:20) writes the data field (word bits 15:0) into the staging register and leaves the DAC code and power state unchanged.
- R2: Opcode 4'h1 copies the staging register into the DAC register and clears power-down, one clock edge after the word strobe.
- R3: Opcode 4'h3 writes the data field into the staging register and copies that new value into the DAC register in the same edge, clearing power-down.
- R4: Opcode 4'h4 sets power-down. Its data field is ignored, and both registers keep their contents.
- R5: Opcode 4'hF and every opcode other than 4'h0, 4'h1, 4'h3 and 4'h4 change neither register nor the power state.
- R6: A falling edge of the load pin, when the transfer flag is low and a word has arrived since the last pin-driven copy, copies the staging register into the DAC register and clears power-down. The edge takes effect on the third clock edge after the pin is sampled low.
- R7: A falling edge of the load pin while the transfer flag is high clears power-down but leaves the DAC register unchanged.
- R8: If the synchronized load pin is low when a word strobe arrives, the word's opcode is executed and the DAC register is then loaded from the staging register. A power-down opcode in that word is suppressed.
- R9: Reset loads both registers with zero, or with 16'h8000 (midscale) when RESET_MID is 1. Reset also clears power-down and busy.
- R10: When power-down clears, the busy flag is high for exactly SETTLE_CYCLES clock edges and then falls. Busy is never high while powered down.
- R11: The data field is MSB-justified in bits 15:0. The 16-RES_BITS low bits of the stored and output code are forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 24 | Received command word: opcode 23:20, unused 19:16, data 15:0 |
| word_valid_i | input | 1 | One-cycle strobe marking a complete word |
| xfer_busy_i | input | 1 | High while a bus word is being received |
| load_n_i | input | 1 | Asynchronous active-low load pin |
| code_o | output | 16 | DAC register, low bits masked per resolution |
| pdown_o | output | 1 | Converter powered down |
| settle_busy_o | output | 1 | Settling window after wake-up is running |

## Verification
Two functions can meet in the same cycle: a word completing, and the load pin acting.

To provoke this, the bench holds the pin low long enough to pass the synchronizer and then strobes words, including a power-down opcode. The judgement is that the word's data reaches the DAC code on the very next edge and that the power-down flag never rises.

The bench also drops the pin while the transfer flag is high. There it checks that the DAC code keeps its old value while the power-down flag clears.

// File: rtl/dac_upd_pkg.sv
`timescale 1ns/1ps
package dac_upd_pkg;

    localparam logic [3:0] OP_WRITE  = 4'h0;
    localparam logic [3:0] OP_UPDATE = 4'h1;
    localparam logic [3:0] OP_WRUPD  = 4'h3;
    localparam logic [3:0] OP_SLEEP  = 4'h4;

    typedef struct packed {
        logic [15:0] stage;   // staging register
        logic [15:0] live;    // DAC register
        logic        pdown;   // powered down
        logic        armed;   // word received since last pin-driven copy
    } ctl_state_t;

    // keep the top res_bits of a 16-bit MSB-justified code
    function automatic logic [15:0] keep_msbs(logic [15:0] raw, int unsigned res_bits);
        logic [15:0] mask;
        mask = 16'hFFFF << (16 - res_bits);
        return raw & mask;
    endfunction

endpackage

// File: rtl/dac_load_sync.sv
`timescale 1ns/1ps
module dac_load_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic level_o,
    output logic fall_o
);
    localparam int unsigned W = STAGES + 1;

    logic [W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[W-2:0], pin_n_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/dac_settle_timer.sv
`timescale 1ns/1ps
module dac_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 2400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic sleep_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (sleep_i)              cnt_d = '0;
        else if (wake_i)          cnt_d = LOAD;
        else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R10: a wake request always opens the window on the next edge
    assert_wake_opens_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i && !sleep_i |=> busy_o);

    // R10: the window never exceeds its configured length
    assert_window_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

endmodule

// File: rtl/dac_update_ctrl.sv
`timescale 1ns/1ps
module dac_update_ctrl
    import dac_upd_pkg::*;
#(
    parameter int unsigned RES_BITS      = 16,
    parameter bit          RESET_MID     = 1'b0,
    parameter int unsigned SETTLE_CYCLES = 2400,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] word_i,
    input  logic        word_valid_i,
    input  logic        xfer_busy_i,
    input  logic        load_n_i,
    output logic [15:0] code_o,
    output logic        pdown_o,
    output logic        settle_busy_o
);
    localparam logic [15:0] RST_CODE = RESET_MID ? 16'h8000 : 16'h0000;

    ctl_state_t st_d, st_q;
    logic       load_lvl, load_fall;
    logic [3:0] opcode;
    logic [15:0] data_in;
    logic       op_write, op_update, op_sleep;

    dac_load_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (load_n_i),
        .level_o (load_lvl),
        .fall_o  (load_fall)
    );

    assign opcode    = word_i[23:20];
    assign data_in   = keep_msbs(word_i[15:0], RES_BITS);
    assign op_write  = (opcode == OP_WRITE)  || (opcode == OP_WRUPD);
    assign op_update = (opcode == OP_UPDATE) || (opcode == OP_WRUPD);
    assign op_sleep  = (opcode == OP_SLEEP);

    always_comb begin
        st_d = st_q;
        if (word_valid_i) begin
            if (op_write) st_d.stage = data_in;
            if (!load_lvl) begin
                // pin held low at word completion: update, no sleep
                st_d.live  = st_d.stage;
                st_d.pdown = 1'b0;
                st_d.armed = 1'b0;
            end else begin
                if (op_update) begin
                    st_d.live  = st_d.stage;
                    st_d.pdown = 1'b0;
                end
                if (op_sleep) st_d.pdown = 1'b1;
                st_d.armed = 1'b1;
            end
        end else if (load_fall) begin
            st_d.pdown = 1'b0;
            if (st_q.armed && !xfer_busy_i) begin
                st_d.live  = st_q.stage;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stage <= RST_CODE;
            st_q.live  <= RST_CODE;
            st_q.pdown <= 1'b0;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    dac_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake_i  (st_q.pdown && !st_d.pdown),
        .sleep_i (st_d.pdown),
        .busy_o  (settle_busy_o)
    );

    assign code_o  = st_q.live;
    assign pdown_o = st_q.pdown;

    // R1: a plain write never moves the DAC code
    assert_write_keeps_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_i && load_lvl && opcode == OP_WRITE |=> $stable(st_q.live));

    // R2: an update opcode wakes the converter and mirrors the staging value
    assert_update_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_i && load_lvl && opcode == OP_UPDATE |=> !st_q.pdown && st_q.live == $past(st_q.stage));

    // R4: power-down keeps both registers
    assert_sleep_keeps_regs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_i && load_lvl && op_sleep |=> st_q.pdown && $stable(st_q.live) && $stable(st_q.stage));

    // R7: a gated pin edge wakes without an update
    assert_gated_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall && xfer_busy_i && !word_valid_i |=> !st_q.pdown && $stable(st_q.live));

    // R8: pin low at word completion forces an update and blocks sleep
    assert_pin_low_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_i && !load_lvl |=> !st_q.pdown && st_q.live == st_q.stage);

    // R10: no settling while powered down
    assert_no_busy_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pdown |-> !settle_busy_o);

endmodule

// File: tb/dac_update_ctrl_test.sv
`timescale 1ns/1ps
module dac_update_ctrl_test;

    localparam int unsigned SETTLE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] word = '0;
    logic        valid = 1'b0;
    logic        xbusy = 1'b0;
    logic        load_n = 1'b1;
    logic [15:0] code_a, code_b;
    logic        pd_a, pd_b, bz_a, bz_b;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dac_update_ctrl #(.RES_BITS(16), .RESET_MID(1'b0), .SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .word_i(word), .word_valid_i(valid),
        .xfer_busy_i(xbusy), .load_n_i(load_n),
        .code_o(code_a), .pdown_o(pd_a), .settle_busy_o(bz_a));

    dac_update_ctrl #(.RES_BITS(12), .RESET_MID(1'b1), .SETTLE_CYCLES(SETTLE)) uut_b (
        .clk(clk), .rst_n(rst_n), .word_i(word), .word_valid_i(valid),
        .xfer_busy_i(xbusy), .load_n_i(load_n),
        .code_o(code_b), .pdown_o(pd_b), .settle_busy_o(bz_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] w);
        @(negedge clk);
        word  = w;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic pin_low();
        @(negedge clk);
        load_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pin_high();
        @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_r9();
        chk("R9 code zero-scale", code_a, 16'h0000);
        chk("R9 code midscale", code_b, 16'h8000);
        chk("R9 pdown", pd_a, 1'b0);
        chk("R9 busy", bz_a, 1'b0);
    endtask

    task automatic t_write_r1();
        send(24'h001234);
        chk("R1 code unchanged", code_a, 16'h0000);
        chk("R1 code unchanged mid", code_b, 16'h8000);
    endtask

    task automatic t_update_r2_r11();
        send(24'h100000);
        chk("R2 code updated", code_a, 16'h1234);
        chk("R11 12-bit mask", code_b, 16'h1230);
        chk("R2 awake no settle", bz_a, 1'b0);
    endtask

    task automatic t_sleep_r4_r10();
        send(24'h40ABCD);
        chk("R4 pdown set", pd_a, 1'b1);
        chk("R4 code kept", code_a, 16'h1234);
        chk("R10 busy low asleep", bz_a, 1'b0);
        send(24'h100000);
        chk("R4 data ignored", code_a, 16'h1234);
        chk("R2 wake", pd_a, 1'b0);
        chk("R10 busy starts", bz_a, 1'b1);
        repeat (SETTLE - 1) @(negedge clk);
        chk("R10 busy last cycle", bz_a, 1'b1);
        @(negedge clk);
        chk("R10 busy ends", bz_a, 1'b0);
    endtask

    task automatic t_write_update_r3();
        send(24'h400000);
        send(24'h305A5A);
        chk("R3 code", code_a, 16'h5A5A);
        chk("R3 wake", pd_a, 1'b0);
        chk("R3 masked", code_b, 16'h5A50);
    endtask

    task automatic t_nop_r5();
        send(24'hF01111);
        send(24'h202222);
        send(24'h803333);
        chk("R5 code kept", code_a, 16'h5A5A);
        chk("R5 pdown kept", pd_a, 1'b0);
        send(24'h100000);
        chk("R5 staging untouched", code_a, 16'h5A5A);
    endtask

    task automatic t_pin_r6();
        send(24'h007777);
        chk("R6 before edge", code_a, 16'h5A5A);
        pin_low();
        chk("R6 pin copy", code_a, 16'h7777);
        pin_high();
    endtask

    task automatic t_gated_r7();
        send(24'h400000);
        send(24'h009999);
        @(negedge clk);
        xbusy = 1'b1;
        pin_low();
        chk("R7 woke", pd_a, 1'b0);
        chk("R7 no update", code_a, 16'h7777);
        pin_high();
        xbusy = 1'b0;
    endtask

    task automatic t_pin_held_r8();
        pin_low();
        chk("R8 armed copy", code_a, 16'h9999);
        send(24'h004321);
        chk("R8 write updates", code_a, 16'h4321);
        send(24'h40ABCD);
        chk("R8 sleep suppressed", pd_a, 1'b0);
        chk("R8 code kept", code_a, 16'h4321);
        pin_high();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r9();
        t_write_r1();
        t_update_r2_r11();
        t_sleep_r4_r10();
        t_write_update_r3();
        t_nop_r5();
        t_pin_r6();
        t_gated_r7();
        t_pin_held_r8();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule